// File: doc/BRIEF.md
# Lockable GPIO Port Controller

This block manages a port of general-purpose pins. Each pin has a data-out bit, a read-only data-in bit and two small configuration registers. Software reaches all of these through a plain register write port and a combinational read port. From each pin's configuration the block derives four pad controls: output-buffer enable, high-side (upper transistor) drive enable, static pull-up enable and input-buffer enable. It also presents the value the pad drives.

A lock bit on each pin freezes that pin's data-out bit and both configuration registers, including the lock bit itself. Only reset or a one-cycle global unlock pulse releases it. A per-pin supply-powered-load flag works with the port-wide no-supply input. When both are set, the pin's output buffer, pull-up and input buffer are shut off. On a pin that is built as output-only, the input buffer is left alone.

The register and pad interfaces are control and status wiring, not data streams. There is no valid/ready handshake and no back-pressure. A write is taken on the clock edge at which `wr_en` is high. A read returns data in the same cycle.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every data-out and configuration bit reads 0. Every pin is then an unlocked input: pad output enable, high-side enable and pull-up are 0, and the input buffer is enabled.
- R2: Register address = {pin index, select[1:0]}, with data 7 bits wide. Select 0 is data-out in bit 0. Select 1 is config-1: bit 0 output enable, bit 1 drive type (1 push-pull, 0 open-drain), bit 2 pull-up, bit 3 lock. Select 2 is config-2: bit 4 supply-powered load, bits 6:5 bus-mode field. Select 3 is data-in in bit 0. Bits a register lacks read 0. A write shows from the next clock edge; a read is combinational.
- R3: In push-pull with output enable set, the pad output and high-side enables are both 1, and the pad value equals data-out.
- R4: In open-drain with output enable set, high-side enable is 0. The output enable is 1 when data-out is 0 (drive low) and 0 when data-out is 1 (released).
- R5: The pull-up follows config-1 bit 2 whether the pin is an input, open-drain or push-pull.
- R6: While a pin's lock bit is set, writes to its data-out, config-1 and config-2 registers change nothing.
- R7: A `unlock_all` pulse clears every lock bit on the following edge. A write in the same cycle is judged by the lock value before the unlock: it is dropped for a locked pin and applied for an unlocked pin, and the written lock bit then stands.
- R8: When a pin's supply-powered-load bit and `no_supply` are both 1, its output enable, high-side enable and pull-up are 0. Its input buffer is also 0, unless the pin is flagged output-only in `OUT_ONLY_MASK`, in which case its input buffer stays 1.
- R9: Data-in shows the pad level two clock edges after it changes, through a two-flop synchronizer. It reads 0 while the input buffer is disabled.
- R10: Writes to the data-in address, and writes to any other pin's registers, leave a pin's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address {pin, select} |
| wr_data | input | 7 | Write data |
| rd_addr | input | AW | Read address {pin, select} |
| rd_data | output | 7 | Read data (combinational) |
| unlock_all | input | 1 | One-cycle pulse clearing every lock bit |
| no_supply | input | 1 | External load supply is absent |
| pad_in | input | N_PINS | Pad levels (asynchronous) |
| pad_out | output | N_PINS | Value driven to each pad |
| pad_oe | output | N_PINS | Output buffer enable |
| pad_hs_en | output | N_PINS | High-side transistor enable |
| pad_pu_en | output | N_PINS | Static pull-up enable |
| pad_ie | output | N_PINS | Input buffer enable |
| bus_mode | output | 2*N_PINS | Bus-mode field of each pin |

## Verification
A register write is due one clock edge after its strobe. The pad controls follow that register change with no further delay. The bench therefore drives every write on a falling edge and checks pad outputs and read data at the next falling edge. Data-in is due two rising edges after a pad change. The bench checks that it is still 0 after one edge and is 1 after the second. Lock and unlock effects are checked one edge after the write or pulse. Load-protection gating is combinational and is sampled one time step after `no_supply` moves.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int REG_W = 7;

  typedef struct packed {
    logic lock;   // bit 3
    logic pu;     // bit 2
    logic pp;     // bit 1
    logic oe;     // bit 0
  } cfg1_t;

  typedef struct packed {
    logic [1:0] bus;  // bits 6:5
    logic       load; // bit 4
  } cfg2_t;

  typedef enum logic [1:0] {
    SEL_DOUT = 2'd0,
    SEL_CFG1 = 2'd1,
    SEL_CFG2 = 2'd2,
    SEL_DIN  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_regs.sv
`timescale 1ns/1ps
module gpio_pin_regs
  import gpio_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dout,
  input  logic             wr_cfg1,
  input  logic             wr_cfg2,
  input  logic [REG_W-1:0] wr_data,
  input  logic             unlock,
  output cfg1_t            cfg1_q,
  output cfg2_t            cfg2_q,
  output logic             dout_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= '0;
      cfg2_q <= '0;
      dout_q <= 1'b0;
    end else if (cfg1_q.lock) begin
      if (unlock) cfg1_q.lock <= 1'b0;
    end else begin
      if (wr_dout) dout_q <= wr_data[0];
      if (wr_cfg1) cfg1_q <= cfg1_t'(wr_data[3:0]);
      if (wr_cfg2) cfg2_q <= cfg2_t'(wr_data[6:4]);
    end
  end

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg1_q.lock && !unlock) |=> ($stable(cfg1_q) && $stable(cfg2_q) && $stable(dout_q)));

  // R7
  unlock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg1_q.lock && unlock) |=> !cfg1_q.lock);
endmodule

// File: rtl/gpio_pad_ctrl.sv
`timescale 1ns/1ps
module gpio_pad_ctrl #(
  parameter bit OUT_ONLY = 1'b0
) (
  input  logic oe,
  input  logic pp,
  input  logic pu,
  input  logic load,
  input  logic dout,
  input  logic no_supply,
  output logic pad_out,
  output logic pad_oe,
  output logic pad_hs_en,
  output logic pad_pu_en,
  output logic pad_ie
);
  logic prot;

  always_comb begin
    prot      = load && no_supply;
    pad_out   = dout;
    pad_hs_en = oe && pp && !prot;
    pad_oe    = oe && !prot && (pp || !dout);
    pad_pu_en = pu && !prot;
    pad_ie    = OUT_ONLY ? 1'b1 : !prot;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int                N_PINS        = 8,
  parameter logic [N_PINS-1:0] OUT_ONLY_MASK = 8'h80,
  parameter int                SYNC_STAGES   = 2,
  localparam int               PW            = $clog2(N_PINS),
  localparam int               AW            = PW + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [REG_W-1:0]    rd_data,
  input  logic                unlock_all,
  input  logic                no_supply,
  input  logic [N_PINS-1:0]   pad_in,
  output logic [N_PINS-1:0]   pad_out,
  output logic [N_PINS-1:0]   pad_oe,
  output logic [N_PINS-1:0]   pad_hs_en,
  output logic [N_PINS-1:0]   pad_pu_en,
  output logic [N_PINS-1:0]   pad_ie,
  output logic [2*N_PINS-1:0] bus_mode
);
  cfg1_t             cfg1_a [N_PINS];
  cfg2_t             cfg2_a [N_PINS];
  logic [N_PINS-1:0] dout_a;
  logic [N_PINS-1:0] sync_a;
  logic [N_PINS-1:0] din_a;

  logic [PW-1:0] wr_pin;
  reg_sel_e      wr_sel;
  logic [PW-1:0] rd_pin;
  reg_sel_e      rd_sel;

  assign wr_pin = wr_addr[AW-1:2];
  assign wr_sel = reg_sel_e'(wr_addr[1:0]);
  assign rd_pin = rd_addr[AW-1:2];
  assign rd_sel = reg_sel_e'(rd_addr[1:0]);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic hit;
    assign hit = wr_en && (wr_pin == PW'(i));

    gpio_pin_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_dout (hit && (wr_sel == SEL_DOUT)),
      .wr_cfg1 (hit && (wr_sel == SEL_CFG1)),
      .wr_cfg2 (hit && (wr_sel == SEL_CFG2)),
      .wr_data (wr_data),
      .unlock  (unlock_all),
      .cfg1_q  (cfg1_a[i]),
      .cfg2_q  (cfg2_a[i]),
      .dout_q  (dout_a[i])
    );

    gpio_pad_ctrl #(.OUT_ONLY(OUT_ONLY_MASK[i])) u_pad (
      .oe        (cfg1_a[i].oe),
      .pp        (cfg1_a[i].pp),
      .pu        (cfg1_a[i].pu),
      .load      (cfg2_a[i].load),
      .dout      (dout_a[i]),
      .no_supply (no_supply),
      .pad_out   (pad_out[i]),
      .pad_oe    (pad_oe[i]),
      .pad_hs_en (pad_hs_en[i]),
      .pad_pu_en (pad_pu_en[i]),
      .pad_ie    (pad_ie[i])
    );

    gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in[i]),
      .q     (sync_a[i])
    );

    assign din_a[i]          = sync_a[i] && pad_ie[i];
    assign bus_mode[2*i +: 2] = cfg2_a[i].bus;

    // R8
    prot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg2_a[i].load && no_supply) |-> !(pad_oe[i] || pad_hs_en[i] || pad_pu_en[i]));

    // R4
    od_hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg1_a[i].oe && !cfg1_a[i].pp) |-> !pad_hs_en[i]);

    // R9
    din_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_ie[i] |-> !din_a[i]);
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_PINS; i++) begin
      if (rd_pin == PW'(i)) begin
        case (rd_sel)
          SEL_DOUT: rd_data = {{(REG_W-1){1'b0}}, dout_a[i]};
          SEL_CFG1: rd_data = {3'b000, cfg1_a[i]};
          SEL_CFG2: rd_data = {cfg2_a[i], 4'b0000};
          default:  rd_data = {{(REG_W-1){1'b0}}, din_a[i]};
        endcase
      end
    end
  end
endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
  localparam int N = 8;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [6:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [6:0]    rd_data;
  logic          unlock_all = 1'b0;
  logic          no_supply = 1'b0;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe, pad_hs_en, pad_pu_en, pad_ie;
  logic [2*N-1:0] bus_mode;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl #(.N_PINS(N), .OUT_ONLY_MASK(8'h80)) i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .unlock_all(unlock_all), .no_supply(no_supply),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_hs_en(pad_hs_en),
    .pad_pu_en(pad_pu_en), .pad_ie(pad_ie), .bus_mode(bus_mode)
  );

  function automatic logic [AW-1:0] adr(input int pin, input int sel);
    return AW'(pin * 4 + sel);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int pin, input int sel, input int data, input bit unl = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = adr(pin, sel); wr_data = 7'(data); unlock_all = unl;
    @(negedge clk);
    wr_en = 1'b0; unlock_all = 1'b0;
  endtask

  task automatic pulse_unlock();
    @(negedge clk); unlock_all = 1'b1;
    @(negedge clk); unlock_all = 1'b0;
  endtask

  task automatic rd(input int pin, input int sel, output int data);
    rd_addr = adr(pin, sel);
    #0.1;
    data = int'(rd_data);
  endtask

  task automatic t_reset();
    int d;
    for (int p = 0; p < N; p++) begin
      for (int s = 0; s < 3; s++) begin
        rd(p, s, d);
        check("R1", $sformatf("reset reg p%0d s%0d", p, s), d, 0);
      end
    end
    check("R1", "reset pad_oe", int'(pad_oe), 0);
    check("R1", "reset pad_hs_en", int'(pad_hs_en), 0);
    check("R1", "reset pad_pu_en", int'(pad_pu_en), 0);
    check("R1", "reset pad_ie", int'(pad_ie), 8'hFF);
  endtask

  task automatic t_map();
    int d;
    wr(2, 1, 7'h77);
    rd(2, 1, d); check("R2", "cfg1 keeps bits 2:0", d, 7'h07);
    wr(3, 2, 7'h7F);
    rd(3, 2, d); check("R2", "cfg2 keeps bits 6:4", d, 7'h70);
    check("R2", "bus_mode pin3", int'(bus_mode[7:6]), 3);
    wr(3, 0, 7'h7F);
    rd(3, 0, d); check("R2", "dout keeps bit 0", d, 1);
    wr(2, 1, 0); wr(3, 2, 0); wr(3, 0, 0);
  endtask

  task automatic t_pushpull();
    wr(1, 1, 7'h03); wr(1, 0, 1);
    check("R3", "pp oe", int'(pad_oe[1]), 1);
    check("R3", "pp hs", int'(pad_hs_en[1]), 1);
    check("R3", "pp out 1", int'(pad_out[1]), 1);
    wr(1, 0, 0);
    check("R3", "pp oe low", int'(pad_oe[1]), 1);
    check("R3", "pp out 0", int'(pad_out[1]), 0);
  endtask

  task automatic t_opendrain();
    wr(4, 1, 7'h01);
    check("R4", "od drive low oe", int'(pad_oe[4]), 1);
    check("R4", "od hs", int'(pad_hs_en[4]), 0);
    check("R4", "od out", int'(pad_out[4]), 0);
    wr(4, 0, 1);
    check("R4", "od released oe", int'(pad_oe[4]), 0);
    check("R4", "od hs released", int'(pad_hs_en[4]), 0);
  endtask

  task automatic t_pullup();
    wr(5, 1, 7'h04);
    check("R5", "pu input", int'(pad_pu_en[5]), 1);
    wr(5, 1, 7'h05);
    check("R5", "pu open-drain", int'(pad_pu_en[5]), 1);
    wr(5, 1, 7'h07);
    check("R5", "pu push-pull", int'(pad_pu_en[5]), 1);
    wr(5, 1, 7'h03);
    check("R5", "pu off", int'(pad_pu_en[5]), 0);
  endtask

  task automatic t_lock();
    int d;
    wr(6, 0, 1); wr(6, 1, 7'h0B);
    wr(6, 1, 0); wr(6, 0, 0); wr(6, 2, 7'h70);
    rd(6, 1, d); check("R6", "locked cfg1", d, 7'h0B);
    rd(6, 0, d); check("R6", "locked dout", d, 1);
    rd(6, 2, d); check("R6", "locked cfg2", d, 0);
    check("R6", "locked pad_oe", int'(pad_oe[6]), 1);
  endtask

  task automatic t_unlock();
    int d;
    wr(0, 1, 7'h08);
    wr(6, 1, 0, 1'b1);  // pin6 locked before: write dropped, lock cleared
    rd(6, 1, d); check("R7", "locked write dropped, lock cleared", d, 7'h03);
    rd(0, 1, d); check("R7", "other pin unlocked", d, 0);
    wr(6, 1, 0);
    rd(6, 1, d); check("R7", "write after unlock", d, 0);
    wr(1, 1, 7'h0B, 1'b1);  // pin1 unlocked before: write applies
    rd(1, 1, d); check("R7", "unlocked write same cycle", d, 7'h0B);
    pulse_unlock();
    rd(1, 1, d); check("R7", "pulse clears lock", d, 7'h03);
  endtask

  task automatic t_protect();
    int d;
    pad_in[1] = 1'b1;
    wr(1, 1, 7'h07); wr(1, 0, 1); wr(1, 2, 7'h10);
    wr(7, 1, 7'h07); wr(7, 0, 1); wr(7, 2, 7'h10);
    check("R8", "no prot oe", int'(pad_oe[1]), 1);
    check("R8", "no prot pu", int'(pad_pu_en[1]), 1);
    rd(1, 3, d); check("R9", "din pin1 high", d, 1);
    no_supply = 1'b1;
    #0.1;
    check("R8", "prot oe", int'(pad_oe[1]), 0);
    check("R8", "prot hs", int'(pad_hs_en[1]), 0);
    check("R8", "prot pu", int'(pad_pu_en[1]), 0);
    check("R8", "prot ie", int'(pad_ie[1]), 0);
    check("R8", "out-only ie kept", int'(pad_ie[7]), 1);
    check("R8", "out-only oe off", int'(pad_oe[7]), 0);
    rd(1, 3, d); check("R9", "din 0 while ie off", d, 0);
    check("R8", "unflagged pin ie", int'(pad_ie[2]), 1);
    no_supply = 1'b0;
    pad_in[1] = 1'b0;
    wr(1, 2, 0); wr(7, 2, 0);
  endtask

  task automatic t_din();
    int d;
    @(negedge clk); pad_in[3] = 1'b1;
    @(negedge clk);
    rd(3, 3, d); check("R9", "din after one edge", d, 0);
    @(negedge clk);
    rd(3, 3, d); check("R9", "din after two edges", d, 1);
  endtask

  task automatic t_ignore();
    int d;
    wr(3, 1, 7'h05);
    wr(3, 3, 7'h7F);
    rd(3, 3, d); check("R10", "din write ignored", d, 1);
    rd(3, 1, d); check("R10", "cfg1 after din write", d, 7'h05);
    rd(3, 0, d); check("R10", "dout after din write", d, 0);
    wr(2, 1, 7'h07); wr(2, 0, 1);
    rd(3, 1, d); check("R10", "neighbour write cfg1", d, 7'h05);
    rd(3, 0, d); check("R10", "neighbour write dout", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_pushpull();
    t_opendrain();
    t_pullup();
    t_lock();
    t_unlock();
    t_protect();
    t_din();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule